// File: doc/BRIEF.md
# USB Device Interrupt Status Unit

This block holds the interrupt status byte of a USB device controller. Six sticky flags record that endpoint 0 needs service, that the receive endpoint needs service, that the transmit endpoint finished a packet, that the bus went into suspend, that the host sent resume signalling, and that the host reset the controller. Each event sets its flag only when the matching bit of the mask vector is clear. Software reads the flags through a byte-wide read port and clears them by writing ones. A single interrupt line is high whenever any flag is set.

The block includes an idle timer. It counts system clock cycles while the bus is idle and declares suspend once the idle time exceeds a threshold set by parameters: clock rate in kHz times idle time in ms, which gives 3 ms by default. The block also tracks a suspended state. Resume is reported only from that state. A host reset clears the rest of the controller state but leaves the reset flag readable afterwards.

Top module: `usb_dev_irq_status`

## Requirements
- R1: After power-on reset all six flags, `rd_data` and `irq` are zero.
- R2: `rd_data` bit 0 is endpoint 0, bit 1 is receive, bit 2 is transmit, bit 3 is suspend, bit 4 is resume and bit 5 is host reset. Bits 7:6 always read zero.
- R3: An event seen on a clock edge sets its flag, visible after that edge, only if `mask` bit i is 0 (mask bit i gates flag bit i). With the mask bit at 1 the event has no effect.
- R4: A cycle with `wr_en` high clears every flag whose bit in `wr_data` is 1. Bits written as 0 leave their flags unchanged.
- R5: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R6: Let LIMIT be CLK_KHZ*IDLE_MS+1. After LIMIT consecutive sampled cycles with `bus_idle` high, the suspend event fires once and the suspended state is entered. Any cycle with `bus_idle` low restarts the count. No second suspend event fires until the bus has been active again.
- R7: `resume_sig` sets the resume flag only while the block is suspended, and resume signalling leaves the suspended state. Outside that state it has no effect on the flags.
- R8: A cycle with `host_reset` high clears flags 0 to 4, the suspended state and the idle count. It sets flag 5 if `mask[5]` is 0. Otherwise flag 5 keeps its value.
- R9: `irq` is high exactly when at least one of the six flags is set.
- R10: Without a write or a host reset, no set flag ever clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ep0_evt | input | 1 | Endpoint 0 needs service (strobe) |
| rx_evt | input | 1 | Receive endpoint needs service (strobe) |
| tx_done | input | 1 | Transmit endpoint completed a packet (strobe) |
| bus_idle | input | 1 | Bus is idle this cycle |
| resume_sig | input | 1 | Bus carries resume signalling |
| host_reset | input | 1 | Host is resetting the controller |
| mask | input | 6 | Per-flag event mask, 1 blocks setting |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | 8 | Write data, ones clear flags |
| rd_data | output | 8 | Status register read value |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk`, and that nothing after the reset release uses values from before it. They are disabled until the internal synchronised reset has released. They also assume that `resume_sig` is asserted only while the bus is active, so that resume and suspend detection never fall in the same cycle. The stimulus drives all inputs on the falling edge. It draws idle periods as runs of random length, some longer and some shorter than the threshold, and it raises `resume_sig` only in cycles where it has dropped `bus_idle`.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned F_EP0     = 0;
  localparam int unsigned F_RX      = 1;
  localparam int unsigned F_TX      = 2;
  localparam int unsigned F_SUSP    = 3;
  localparam int unsigned F_RES     = 4;
  localparam int unsigned F_HRST    = 5;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/usb_irq_rst_sync.sv
module usb_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int unsigned LIMIT = 300001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_idle,
  input  logic restart,
  output logic expire
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM   = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] LIM_M = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (restart || !bus_idle) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIM) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = bus_idle && !restart && (cnt_q == LIM_M);
endmodule

// File: rtl/usb_suspend_track.sv
module usb_suspend_track (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_expire,
  input  logic resume_sig,
  input  logic host_reset,
  output logic suspended,
  output logic resume_evt
);
  logic susp_q;
  logic susp_d;
  logic susp_en;

  always_comb begin
    susp_d = susp_q;
    if (host_reset || resume_sig) susp_d = 1'b0;
    else if (idle_expire)         susp_d = 1'b1;
    susp_en = (susp_d != susp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       susp_q <= 1'b0;
    else if (susp_en) susp_q <= susp_d;
  end

  assign suspended  = susp_q;
  assign resume_evt = susp_q && resume_sig && !host_reset;
endmodule

// File: rtl/usb_irq_flag_bank.sv
module usb_irq_flag_bank
  import usb_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_req,
  input  flag_vec_t w1c_req,
  input  flag_vec_t force_clr,
  output flag_vec_t flags
);
  flag_vec_t flag_q;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic bit_d;
    logic bit_en;
    always_comb begin
      if (force_clr[i])    bit_d = 1'b0;
      else if (set_req[i]) bit_d = 1'b1;
      else if (w1c_req[i]) bit_d = 1'b0;
      else                 bit_d = flag_q[i];
      bit_en = (bit_d != flag_q[i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (bit_en) flag_q[i] <= bit_d;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/usb_dev_irq_status.sv
module usb_dev_irq_status
  import usb_irq_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned IDLE_MS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ep0_evt,
  input  logic       rx_evt,
  input  logic       tx_done,
  input  logic       bus_idle,
  input  logic       resume_sig,
  input  logic       host_reset,
  input  logic [5:0] mask,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int unsigned IDLE_CYCLES = CLK_KHZ * IDLE_MS;
  localparam int unsigned LIMIT       = IDLE_CYCLES + 1;

  logic      rst_sync_n;
  logic      idle_expire;
  logic      susp_q;
  logic      resume_evt;
  flag_vec_t evt_vec;
  flag_vec_t set_req;
  flag_vec_t w1c_req;
  flag_vec_t force_clr;
  flag_vec_t flags;
  logic      unused_wr_hi;

  usb_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  usb_idle_timer #(.LIMIT(LIMIT)) u_idle (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_idle (bus_idle),
    .restart  (host_reset),
    .expire   (idle_expire)
  );

  usb_suspend_track u_susp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .idle_expire (idle_expire),
    .resume_sig  (resume_sig),
    .host_reset  (host_reset),
    .suspended   (susp_q),
    .resume_evt  (resume_evt)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[F_EP0]   = ep0_evt;
    evt_vec[F_RX]    = rx_evt;
    evt_vec[F_TX]    = tx_done;
    evt_vec[F_SUSP]  = idle_expire;
    evt_vec[F_RES]   = resume_evt;
    evt_vec[F_HRST]  = host_reset;
    set_req          = evt_vec & ~mask;
    w1c_req          = wr_en ? wr_data[NUM_FLAGS-1:0] : '0;
    force_clr        = {NUM_FLAGS{host_reset}};
    force_clr[F_HRST] = 1'b0;
  end

  usb_irq_flag_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_req   (set_req),
    .w1c_req   (w1c_req),
    .force_clr (force_clr),
    .flags     (flags)
  );

  assign unused_wr_hi = ^wr_data[REG_W-1:NUM_FLAGS];
  assign rd_data      = {{(REG_W-NUM_FLAGS){1'b0}}, flags};
  assign irq          = |flags;
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ep0_evt,
  input logic       rx_evt,
  input logic       tx_done,
  input logic       host_reset,
  input logic [5:0] mask,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       suspended
);
  assert_ep0_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ep0_evt && !mask[0] && !host_reset) |=> rd_data[0]);

  assert_masked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[1] && mask[1]) |=> !rd_data[1]);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2] && !(tx_done && !mask[2])) |=> !rd_data[2]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && rx_evt && !mask[1] && !host_reset) |=> rd_data[1]);

  assert_resume_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspended && !rd_data[4]) |=> !rd_data[4]);

  assert_host_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_reset |=> (rd_data[4:0] == 5'd0 && !suspended));

  assert_reset_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_reset && !mask[5]) |=> rd_data[5]);

  assert_irq_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[5:0] != 6'd0));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !host_reset) |=>
      ((rd_data[5:0] & $past(rd_data[5:0])) == $past(rd_data[5:0])));
endmodule

bind usb_dev_irq_status usb_irq_status_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ep0_evt    (ep0_evt),
  .rx_evt     (rx_evt),
  .tx_done    (tx_done),
  .host_reset (host_reset),
  .mask       (mask),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .irq        (irq),
  .suspended  (susp_q)
);

// File: tb/usb_dev_irq_status_tb_top.sv
module usb_dev_irq_status_tb_top;
  localparam int CLK_KHZ = 10;
  localparam int IDLE_MS = 3;
  localparam int LIMIT   = CLK_KHZ * IDLE_MS + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ep0_evt = 1'b0, rx_evt = 1'b0, tx_done = 1'b0;
  logic       bus_idle = 1'b0, resume_sig = 1'b0, host_reset = 1'b0;
  logic [5:0] mask = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int   vecs = 0;
  int   bad  = 0;
  bit   done = 0;
  logic [5:0] mf = '0;
  int   mcnt = 0;
  bit   msusp = 0;

  always #5 clk = ~clk;

  usb_dev_irq_status #(.CLK_KHZ(CLK_KHZ), .IDLE_MS(IDLE_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ep0_evt(ep0_evt), .rx_evt(rx_evt),
    .tx_done(tx_done), .bus_idle(bus_idle), .resume_sig(resume_sig),
    .host_reset(host_reset), .mask(mask), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic bit calc_expire(bit idle, bit hr, int cnt);
    return idle && !hr && (cnt == LIMIT - 1);
  endfunction

  function automatic logic [5:0] calc_flags(logic [5:0] f, bit exp_i, bit susp);
    logic [5:0] setv, clr, nf;
    setv = {host_reset, susp && resume_sig && !host_reset, exp_i,
            tx_done, rx_evt, ep0_evt} & ~mask;
    clr  = wr_en ? wr_data[5:0] : 6'd0;
    nf   = (f & ~clr) | setv;
    if (host_reset) nf[4:0] = 5'd0;
    return nf;
  endfunction

  task automatic model_edge();
    bit ex;
    ex = calc_expire(bus_idle, host_reset, mcnt);
    mf = calc_flags(mf, ex, msusp);
    if (host_reset || resume_sig) msusp = 0;
    else if (ex)                  msusp = 1;
    if (host_reset || !bus_idle)  mcnt = 0;
    else if (mcnt != LIMIT)       mcnt = mcnt + 1;
  endtask

  task automatic check(bit ok, string tag, logic [7:0] got, logic [7:0] exp_v);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp_v);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(rd_data == {2'b00, mf}, tag, rd_data, {2'b00, mf});
    check(irq == (mf != 0), {tag, "/R9 irq"}, {7'd0, irq}, {7'd0, mf != 0});
  endtask

  task automatic quiet();
    ep0_evt = 0; rx_evt = 0; tx_done = 0; resume_sig = 0;
    host_reset = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int run;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rd_data == 8'h00, "R1 reset rd_data", rd_data, 8'h00);
    check(irq == 1'b0, "R1 reset irq", {7'd0, irq}, 8'h00);

    // R3: unmasked endpoint 0 event, masked receive event
    mask = 6'b000010; ep0_evt = 1; rx_evt = 1;
    step("R3 mask gating");
    quiet();
    check(rd_data[1:0] == 2'b01, "R3 masked rx ignored", rd_data, 8'h01);
    mask = 6'b000000; rx_evt = 1; tx_done = 1;
    step("R3 rx/tx set"); quiet();
    // R2: bit layout, upper bits zero
    check(rd_data == 8'h07, "R2 layout", rd_data, 8'h07);

    // R4: writing zeros has no effect, ones clear
    wr_en = 1; wr_data = 8'hF8; step("R4 write zeros"); quiet();
    check(rd_data == 8'h07, "R4 zeros keep", rd_data, 8'h07);
    wr_en = 1; wr_data = 8'h01; step("R4 write one"); quiet();
    check(rd_data == 8'h06, "R4 clear bit0", rd_data, 8'h06);

    // R5: set beats clear in the same cycle
    wr_en = 1; wr_data = 8'h04; tx_done = 1; step("R5 set wins"); quiet();
    check(rd_data[2] == 1'b1, "R5 tx kept", rd_data, 8'h06);
    wr_en = 1; wr_data = 8'h3F; step("R4 clear all"); quiet();

    // R7: resume outside suspend is ignored
    resume_sig = 1; step("R7 resume not suspended"); quiet();
    check(rd_data[4] == 1'b0, "R7 no resume flag", rd_data, 8'h00);

    // R6: threshold boundary
    bus_idle = 1;
    repeat (LIMIT - 1) step("R6 idle below limit");
    check(rd_data[3] == 1'b0, "R6 not yet suspended", rd_data, 8'h00);
    step("R6 idle at limit");
    check(rd_data[3] == 1'b1, "R6 suspend flag", rd_data, 8'h08);
    wr_en = 1; wr_data = 8'h08; step("R6 clear suspend"); quiet();
    repeat (40) step("R6 no second event");
    check(rd_data[3] == 1'b0, "R6 single event", rd_data, 8'h00);
    bus_idle = 0; resume_sig = 1; step("R7 resume while suspended"); quiet();
    check(rd_data[4] == 1'b1, "R7 resume flag", rd_data, 8'h10);
    wr_en = 1; wr_data = 8'h10; step("R7 clear"); quiet();
    resume_sig = 1; step("R7 resume after exit"); quiet();
    check(rd_data[4] == 1'b0, "R7 state left", rd_data, 8'h00);

    // R6: activity restarts the count
    bus_idle = 1; repeat (LIMIT - 5) step("R6 idle part1");
    bus_idle = 0; step("R6 activity");
    bus_idle = 1; repeat (LIMIT - 5) step("R6 idle part2");
    check(rd_data[3] == 1'b0, "R6 restart", rd_data, 8'h00);

    // R8: host reset
    bus_idle = 0; ep0_evt = 1; rx_evt = 1; step("R8 prep"); quiet();
    host_reset = 1; step("R8 host reset"); quiet();
    check(rd_data == 8'h20, "R8 reset flag only", rd_data, 8'h20);
    ep0_evt = 1; step("R8 prep2"); quiet();
    mask = 6'b100000; host_reset = 1; step("R8 masked reset keeps"); quiet();
    check(rd_data == 8'h20, "R8 flag5 retained", rd_data, 8'h20);
    mask = 0; wr_en = 1; wr_data = 8'h20; step("R4 clear flag5"); quiet();
    check(rd_data == 8'h00, "R4 flag5 cleared", rd_data, 8'h00);
    host_reset = 1; mask = 6'b100000; step("R8 masked reset clear"); quiet();
    check(rd_data[5] == 1'b0, "R8 masked no set", rd_data, 8'h00);

    // random phase: R3 R4 R5 R6 R7 R8 R9 R10
    run = 0;
    for (int n = 0; n < 4000; n++) begin
      if (run == 0) begin
        bus_idle = ~bus_idle;
        run = bus_idle ? int'($urandom_range(60, 1)) : int'($urandom_range(6, 1));
      end
      run--;
      ep0_evt    = ($urandom_range(7, 0) == 0);
      rx_evt     = ($urandom_range(7, 0) == 0);
      tx_done    = ($urandom_range(7, 0) == 0);
      resume_sig = !bus_idle && ($urandom_range(3, 0) == 0);
      host_reset = ($urandom_range(199, 0) == 0);
      wr_en      = ($urandom_range(5, 0) == 0);
      wr_data    = 8'($urandom);
      if ($urandom_range(49, 0) == 0) mask = 6'($urandom);
      step("R10 random");
    end
    quiet();
    finish_run();
  end
endmodule